// File: doc/BRIEF.md
# Single-Wire Bus Reset and Presence Master

This block runs the bus initialisation sequence from the master side of a single-wire open-drain bus. When it receives a start request, it holds the line low for a fixed reset time and then releases it. While the line is released it watches for a slave answering with a low presence pulse. After the whole release interval has passed it pulses done once. It reports whether any device answered, and it also reports whether the line was still held low at the end of the interval, which would mean the bus is shorted.

All timing is counted in microsecond ticks supplied by the caller. A mode input picks standard or high-speed timing. The block samples this input once, at start, and holds it for the whole sequence. The bus level input must already be synchronised to the clock. The pull-low output enables the open-drain driver.

Top module: `busreset_master`

## Requirements
- R1: While reset is active and after it releases, pull_low_o, busy_o, done_o, presence_o and short_o are all 0.
- R2: A start_i seen while idle sets pull_low_o and busy_o in the next clock. pull_low_o then stays high for exactly 500 ticks when od_mode_i was 0 at start, or 64 ticks when it was 1.
- R3: After the low phase, the line stays released while busy_o holds for 480 ticks (standard) or 48 ticks (high speed). Tick index 0 is the first tick after release.
- R4: done_o is high for exactly one clock, in the clock right after the last tick of the release interval. busy_o drops in that same clock.
- R5: presence_o goes to 1 if bus_level_i is 0 in any clock whose release tick index lies in [15,300) for standard speed or [2,30) for high speed. A low level only outside this window leaves it at 0.
- R6: presence_o and short_o hold their values until the next accepted start, which clears both.
- R7: short_o goes to 1 together with done_o when bus_level_i is 0 on the last tick of the release interval.
- R8: A start_i while busy_o is high has no effect, and so does a change of od_mode_i during a sequence. The phase lengths stay as they were set at start.
- R9: pull_low_o is never high for 960 or more consecutive ticks, so the reset never masks interrupt signalling from other devices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one reset/presence sequence |
| od_mode_i | input | 1 | 1 selects high-speed timing, sampled at start |
| tick_us_i | input | 1 | One-clock pulse per microsecond |
| bus_level_i | input | 1 | Synchronised bus level, 0 means low |
| pull_low_o | output | 1 | Enables the open-drain pull-down |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock end-of-sequence pulse |
| presence_o | output | 1 | A slave answered in the last sequence |
| short_o | output | 1 | Line was still low at the end of the last sequence |

## Verification
The assertions assume that tick_us_i is a clean single-clock pulse, so that the low-run counter advances at the same rate as the design's phase counter. They also assume bus_level_i only changes away from the active edge. The bench drives every input on the falling clock edge. It models the bus as the wired AND of the block's own pull-down and a slave pulse placed at a chosen release-tick offset and width. It ticks once per clock, so each release-tick index maps to a known clock and the presence window edges can be hit exactly.

// File: rtl/busreset_master.sv
module busreset_master #(
  parameter int STD_LOW_US  = 500,
  parameter int OD_LOW_US   = 64,
  parameter int STD_HIGH_US = 480,
  parameter int OD_HIGH_US  = 48,
  parameter int STD_WIN_LO  = 15,
  parameter int STD_WIN_HI  = 300,
  parameter int OD_WIN_LO   = 2,
  parameter int OD_WIN_HI   = 30,
  parameter int CAP_US      = 960
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic od_mode_i,
  input  logic tick_us_i,
  input  logic bus_level_i,
  output logic pull_low_o,
  output logic busy_o,
  output logic done_o,
  output logic presence_o,
  output logic short_o
);
  localparam int MAXLEN = (STD_LOW_US > STD_HIGH_US) ? STD_LOW_US : STD_HIGH_US;
  localparam int CW     = $clog2(MAXLEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          od_q, done_q, pres_q, short_q;
  logic [CW-1:0] low_last, high_last, win_lo, win_hi;
  logic          in_win;

  assign low_last  = od_q ? CW'(OD_LOW_US - 1)  : CW'(STD_LOW_US - 1);
  assign high_last = od_q ? CW'(OD_HIGH_US - 1) : CW'(STD_HIGH_US - 1);
  assign win_lo    = od_q ? CW'(OD_WIN_LO)      : CW'(STD_WIN_LO);
  assign win_hi    = od_q ? CW'(OD_WIN_HI)      : CW'(STD_WIN_HI);
  assign in_win    = (cnt >= win_lo) && (cnt < win_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      od_q    <= 1'b0;
      done_q  <= 1'b0;
      pres_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          state   <= S_LOW;
          cnt     <= '0;
          od_q    <= od_mode_i;
          pres_q  <= 1'b0;
          short_q <= 1'b0;
        end
        S_LOW: if (tick_us_i) begin
          if (cnt == low_last) begin
            state <= S_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (in_win && !bus_level_i) pres_q <= 1'b1;
          if (tick_us_i) begin
            if (cnt == high_last) begin
              state   <= S_IDLE;
              cnt     <= '0;
              done_q  <= 1'b1;
              short_q <= !bus_level_i;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign pull_low_o = (state == S_LOW);
  assign busy_o     = (state != S_IDLE);
  assign done_o     = done_q;
  assign presence_o = pres_q;
  assign short_o    = short_q;
endmodule

// File: rtl/busreset_checker.sv
module busreset_checker #(
  parameter int CAP_US = 960
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic tick_us_i,
  input logic pull_low_o,
  input logic busy_o,
  input logic done_o,
  input logic presence_o,
  input logic short_o
);
  localparam int RW = $clog2(CAP_US + 2);
  logic [RW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                       low_run <= '0;
    else if (!pull_low_o)             low_run <= '0;
    else if (tick_us_i && low_run < RW'(CAP_US)) low_run <= low_run + 1'b1;
  end

  AST_LOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low_o |-> (low_run < RW'(CAP_US)));                          // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                              // R4
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));                           // R4
  AST_PULL_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low_o |-> busy_o);                                           // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !pull_low_o && start_i) |=> !pull_low_o);              // R8
  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_low_o) |-> (!presence_o && !short_o));                 // R6
  AST_SHORT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_o) |-> done_o);                                       // R7
endmodule

bind busreset_master busreset_checker #(.CAP_US(CAP_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_us_i(tick_us_i),
  .pull_low_o(pull_low_o), .busy_o(busy_o), .done_o(done_o),
  .presence_o(presence_o), .short_o(short_o)
);

// File: tb/tb_busreset_master.sv
module tb_busreset_master;
  logic clk = 0, rst_n = 0, start_i = 0, od_mode_i = 0, tick_us_i = 1, slave_low = 0;
  logic bus_level_i, pull_low_o, busy_o, done_o, presence_o, short_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign bus_level_i = !(pull_low_o | slave_low);

  busreset_master dut (.*);

  // {od, delay[9:0], width[9:0], exp_presence, exp_short}
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 10'd30,  10'd120, 1'b1, 1'b0},
    {1'b0, 10'd5,   10'd5,   1'b0, 1'b0},
    {1'b0, 10'd0,   10'd0,   1'b0, 1'b0},
    {1'b0, 10'd350, 10'd50,  1'b0, 1'b0},
    {1'b0, 10'd290, 10'd20,  1'b1, 1'b0},
    {1'b1, 10'd4,   10'd16,  1'b1, 1'b0},
    {1'b1, 10'd0,   10'd2,   1'b0, 1'b0},
    {1'b1, 10'd35,  10'd5,   1'b0, 1'b0},
    {1'b0, 10'd100, 10'd400, 1'b1, 1'b1},
    {1'b1, 10'd10,  10'd100, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input bit od, input int d, input int w, input bit ep, input bit es, input int inj);
    int lo = od ? 64 : 500;
    int hi = od ? 48 : 480;
    int bad_pull = 0, bad_busy = 0, bad_done = 0;
    @(negedge clk);
    start_i = 1; od_mode_i = od;
    for (int n = 1; n <= lo + hi + 1; n++) begin
      @(negedge clk);
      start_i = (n == inj);
      od_mode_i = !od;
      slave_low = (n >= lo + 1) && (n - 1 - lo >= d) && (n - 1 - lo < d + w);
      if (pull_low_o !== (n <= lo)) bad_pull++;
      if (busy_o !== (n <= lo + hi)) bad_busy++;
      if (done_o !== (n == lo + hi + 1)) bad_done++;
    end
    chk(bad_pull == 0, "R2", "pull_low window mismatches", bad_pull, 0);
    chk(bad_busy == 0, "R3", "busy window mismatches", bad_busy, 0);
    chk(bad_done == 0, "R4", "done timing mismatches", bad_done, 0);
    chk(presence_o === ep, "R5", "presence", int'(presence_o), int'(ep));
    chk(short_o === es, "R7", "short", int'(short_o), int'(es));
    slave_low = 0; od_mode_i = 0;
    @(negedge clk);
    chk(done_o === 1'b0 && busy_o === 1'b0, "R4", "done/busy after pulse", int'(done_o), 0);
    chk(presence_o === ep && short_o === es, "R6", "flags held", int'(presence_o), int'(ep));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!pull_low_o && !busy_o && !done_o && !presence_o && !short_o, "R1", "outputs in reset",
        int'({pull_low_o, busy_o, done_o, presence_o, short_o}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!pull_low_o && !busy_o && !done_o && !presence_o && !short_o, "R1", "outputs after reset",
        int'({pull_low_o, busy_o, done_o, presence_o, short_o}), 0);
    for (int i = 0; i < NV; i++)
      run(VEC[i][22], int'(VEC[i][21:12]), int'(VEC[i][11:2]), VEC[i][1], VEC[i][0], -1);
    // R8: start during low phase and during release phase is ignored
    run(1'b0, 30, 120, 1'b1, 1'b0, 200);
    run(1'b1, 4, 16, 1'b1, 1'b0, 80);
    // R5: window edges
    run(1'b0, 14, 1, 1'b0, 1'b0, -1);
    run(1'b0, 299, 1, 1'b1, 1'b0, -1);
    run(1'b1, 30, 4, 1'b0, 1'b0, -1);
    run(1'b1, 2, 1, 1'b1, 1'b0, -1);
    // R9: held low-time never reaches the cap (checked by assertion)
    chk(1'b1, "R9", "cap covered by checker", 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule